// File: doc/BRIEF.md
# Transmit Descriptor Ring with Low-Watermark Interrupt

This block is a circular transmit descriptor queue. A producer pushes descriptors in at one port, and a built-in drain engine takes them out in strict ring order. The drain retires at most one descriptor per programmable pacing interval. When every slot is occupied, the producer port deasserts its ready signal and accepts nothing until the drain frees a slot.

When a push fills the ring, the block embeds a wake-up flag in the descriptor that sits a quarter of the ring depth ahead of the read pointer. This descriptor is retired well before the ring empties. When the drain reaches it, a sticky interrupt bit is raised, so that software stalled on a full ring can refill the queue before it runs dry. The interrupt does not compare the occupancy against a threshold. It follows one chosen descriptor through the queue. If the drain keeps pace with the producer, the ring never fills, no descriptor is flagged, and no interrupt is generated.

Top module: `tx_wm_ring`

## Requirements
- R1: After reset the ring is empty: `level` is 0, `enq_ready` is 1 and `irq_status` is 0. `level` always equals the number of stored descriptors and never exceeds DEPTH.
- R2: `enq_ready` is low exactly when `level` equals DEPTH. A push offered while `enq_ready` is low is ignored: it neither changes `level` nor appears on the drain side. Readiness returns in the cycle after a drain retirement frees a slot.
- R3: Descriptors appear on `done_data` in exactly the order in which they were accepted.
- R4: The drain uses a cycle timer that is held at zero while the ring is empty and counts up while the ring is non-empty. `done_valid` is high in the cycle where the timer has reached P-1, where P is the `period` input and a value of 0 is treated as 1. The timer restarts from zero after each retirement. With the ring empty, `done_valid` stays low.
- R5: A push can fill the ring (level goes from DEPTH-1 to DEPTH, with no retirement in the same cycle). If no flag is outstanding at that moment, the slot at read pointer + DEPTH/4 (mod DEPTH) is flagged. That slot is the (DEPTH/4+1)-th descriptor to be retired from then on, and `done_mark` is high when it is retired.
- R6: At most one stored descriptor carries the flag. No new flag is placed while one is outstanding, and the flag is removed when its descriptor is retired. If the ring never fills, `done_mark` and `irq_status` stay low.
- R7: `irq_status` rises in the cycle after a flagged descriptor is retired. It stays high until a cycle with `irq_clear` high, and then reads 0 in the following cycle. If a flagged retirement and `irq_clear` occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Producer offers a descriptor |
| enq_data | input | DW | Descriptor payload |
| enq_ready | output | 1 | Ring has a free slot; push is taken when valid and ready |
| period | input | 8 | Drain pacing interval in cycles (0 acts as 1) |
| done_valid | output | 1 | A descriptor is retired this cycle |
| done_data | output | DW | Payload of the retired descriptor |
| done_mark | output | 1 | Retired descriptor carries the wake-up flag |
| irq_status | output | 1 | Sticky low-watermark interrupt |
| irq_clear | input | 1 | Write-one-to-clear for `irq_status` |
| level | output | $clog2(DEPTH+1) | Number of stored descriptors |

## Verification
The outputs `done_valid`, `done_data`, `done_mark`, `enq_ready` and `level` are all decoded from state registers. They therefore reflect in the same cycle the state left by the previous edge. `irq_status` is registered and changes one edge after the flagged retirement or the clear. The bench applies each input at the falling edge, waits one nanosecond and compares every output against an arithmetic ring model that has been advanced once per rising edge. Each result is therefore checked in the cycle it is due and never a cycle late. Pacing values from 0 to 4 are swept with an 8-deep ring, using slow, burst and pseudo-random push and clear patterns.

// File: rtl/tx_wm_pkg.sv
package tx_wm_pkg;

    localparam int PERIOD_W = 8;

    typedef logic [PERIOD_W-1:0] period_t;

    typedef enum logic [1:0] {
        RING_EMPTY   = 2'd0,
        RING_PARTIAL = 2'd1,
        RING_FULL    = 2'd2
    } ring_state_e;

    typedef struct packed {
        logic fire;
        logic mark;
    } pop_info_t;

    function automatic period_t eff_period(input period_t p);
        return (p == '0) ? period_t'(1) : p;
    endfunction

endpackage

// File: rtl/tx_wm_pacer.sv
module tx_wm_pacer
    import tx_wm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    busy,
    input  period_t period,
    output logic    fire
);
    period_t tmr;
    period_t limit;

    assign limit = eff_period(period) - period_t'(1);
    assign fire  = busy && (tmr >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr <= '0;
        end else if (!busy || fire) begin
            tmr <= '0;
        end else begin
            tmr <= tmr + period_t'(1);
        end
    end
endmodule

// File: rtl/tx_wm_ptrs.sv
module tx_wm_ptrs
    import tx_wm_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output ring_state_e   state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            if (pop)  rd_ptr <= rd_ptr + AW'(1);
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_comb begin
        if (count == '0)
            state = RING_EMPTY;
        else if (count == CW'(DEPTH))
            state = RING_FULL;
        else
            state = RING_PARTIAL;
    end
endmodule

// File: rtl/tx_wm_store.sv
module tx_wm_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             flag_set,
    input  logic [AW-1:0]    flag_idx,
    input  logic             clr_en,
    input  logic [AW-1:0]    rd_idx,
    output logic [DW-1:0]    rd_data,
    output logic             rd_flag,
    output logic [DEPTH-1:0] flag_bits
);
    logic [DW-1:0]    data_q [DEPTH];
    logic [DEPTH-1:0] flag_q;
    logic [DEPTH-1:0] wr_sel;
    logic [DEPTH-1:0] set_sel;
    logic [DEPTH-1:0] clr_sel;

    for (genvar i = 0; i < DEPTH; i++) begin : g_sel
        assign wr_sel[i]  = wr_en    && (wr_idx   == AW'(i));
        assign set_sel[i] = flag_set && (flag_idx == AW'(i));
        assign clr_sel[i] = clr_en   && (rd_idx   == AW'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_sel[i]) data_q[i] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (set_sel[i])
                    flag_q[i] <= 1'b1;
                else if (wr_sel[i] || clr_sel[i])
                    flag_q[i] <= 1'b0;
            end
        end
    end

    assign rd_data   = data_q[rd_idx];
    assign rd_flag   = flag_q[rd_idx];
    assign flag_bits = flag_q;
endmodule

// File: rtl/tx_wm_ring.sv
module tx_wm_ring
    import tx_wm_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         enq_valid,
    input  logic [DW-1:0]                enq_data,
    output logic                         enq_ready,
    input  logic [PERIOD_W-1:0]          period,
    output logic                         done_valid,
    output logic [DW-1:0]                done_data,
    output logic                         done_mark,
    output logic                         irq_status,
    input  logic                         irq_clear,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW  = $clog2(DEPTH);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int QTR = DEPTH / 4;

    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    ring_state_e      state;
    logic             push;
    logic             fire;
    logic             arm;
    logic [AW-1:0]    flag_idx;
    logic [DEPTH-1:0] mark_bits;
    logic             rd_flag;
    pop_info_t        pinfo;

    assign enq_ready = (state != RING_FULL);
    assign push      = enq_valid && enq_ready;

    tx_wm_pacer u_pacer (
        .clk    (clk),
        .rst    (rst),
        .busy   (state != RING_EMPTY),
        .period (period),
        .fire   (fire)
    );

    tx_wm_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
        .clk    (clk),
        .rst    (rst),
        .push   (push),
        .pop    (fire),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .count  (count),
        .state  (state)
    );

    // A push that takes the last free slot arms the wake-up flag
    assign arm      = push && !fire && (count == CW'(DEPTH - 1)) && (mark_bits == '0);
    assign flag_idx = rd_ptr + AW'(QTR);

    tx_wm_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (push),
        .wr_idx    (wr_ptr),
        .wr_data   (enq_data),
        .flag_set  (arm),
        .flag_idx  (flag_idx),
        .clr_en    (fire),
        .rd_idx    (rd_ptr),
        .rd_data   (done_data),
        .rd_flag   (rd_flag),
        .flag_bits (mark_bits)
    );

    assign pinfo = '{fire: fire, mark: rd_flag};

    always_ff @(posedge clk) begin
        if (rst)
            irq_status <= 1'b0;
        else if (pinfo.fire && pinfo.mark)
            irq_status <= 1'b1;
        else if (irq_clear)
            irq_status <= 1'b0;
    end

    assign done_valid = pinfo.fire;
    assign done_mark  = pinfo.fire && pinfo.mark;
    assign level      = count;
endmodule

// File: rtl/tx_wm_ring_chk.sv
module tx_wm_ring_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             enq_valid,
    input logic             enq_ready,
    input logic             done_valid,
    input logic             done_mark,
    input logic             irq_status,
    input logic             irq_clear,
    input logic [CW-1:0]    level,
    input logic [DEPTH-1:0] mark_bits
);
    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH)); // R1
    AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !(enq_valid && enq_ready)) |=> (level == $past(level) - CW'(1))); // R1
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!enq_ready && !done_valid) |=> (level == $past(level))); // R2
    AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!enq_ready && done_valid) |=> enq_ready); // R2
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |-> !done_valid); // R4
    AST_ONE_MARK: assert property (@(posedge clk) disable iff (rst)
        $countones(mark_bits) <= 1); // R6
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_status && !irq_clear) |=> irq_status); // R7
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_status) |-> $past(done_valid && done_mark)); // R7
    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_mark) |=> irq_status); // R7
endmodule

bind tx_wm_ring tx_wm_ring_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH + 1))) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enq_valid  (enq_valid),
    .enq_ready  (enq_ready),
    .done_valid (done_valid),
    .done_mark  (done_mark),
    .irq_status (irq_status),
    .irq_clear  (irq_clear),
    .level      (level),
    .mark_bits  (mark_bits)
);

// File: tb/tx_wm_ring_bench.sv
`timescale 1ns/1ps
module tx_wm_ring_bench;
    localparam int D  = 8;
    localparam int DW = 8;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enq_valid = 1'b0;
    logic [DW-1:0] enq_data = '0;
    logic          enq_ready;
    logic [7:0]    period = 8'd1;
    logic          done_valid;
    logic [DW-1:0] done_data;
    logic          done_mark;
    logic          irq_status;
    logic          irq_clear = 1'b0;
    logic [CW-1:0] level;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference ring state
    int m_q [D];
    bit m_k [D];
    int m_rd = 0, m_wr = 0, m_cnt = 0, m_tmr = 0;
    bit m_irq = 0;
    int marks_seen = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  tag = 8'd1;

    tx_wm_ring #(.DEPTH(D), .DW(DW)) u_tx_wm_ring (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_data(enq_data),
        .enq_ready(enq_ready), .period(period), .done_valid(done_valid),
        .done_data(done_data), .done_mark(done_mark), .irq_status(irq_status),
        .irq_clear(irq_clear), .level(level)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d exp %0d", what, got, exp);
        end
    endtask

    function automatic bit any_mark();
        for (int i = 0; i < D; i++) if (m_k[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(input bit v, input logic [DW-1:0] d, input bit c);
        int eff;
        bit pop, acc, setirq;
        enq_valid = v; enq_data = d; irq_clear = c;
        #1;
        eff = (period == 0) ? 1 : int'(period);
        pop = (m_cnt != 0) && (m_tmr >= eff - 1);
        acc = v && (m_cnt != D);
        chk("R1 level", int'(level), m_cnt);
        chk("R2 enq_ready", int'(enq_ready), int'(m_cnt != D));
        chk("R4 done_valid", int'(done_valid), int'(pop));
        if (pop) begin
            chk("R3 done_data", int'(done_data), m_q[m_rd]);
            chk("R5 done_mark", int'(done_mark), int'(m_k[m_rd]));
        end
        chk("R7 irq_status", int'(irq_status), int'(m_irq));
        setirq = 0;
        if (pop) begin
            if (m_k[m_rd]) begin setirq = 1; marks_seen++; end
            m_k[m_rd] = 0;
            m_rd = (m_rd + 1) % D;
            m_tmr = 0;
        end else if (m_cnt != 0) m_tmr++;
        else m_tmr = 0;
        if (acc && !pop && m_cnt == D - 1 && !any_mark())
            m_k[(m_rd + D / 4) % D] = 1;
        if (acc) begin
            m_q[m_wr] = int'(d); m_k[m_wr] = 0;
            m_wr = (m_wr + 1) % D;
        end
        m_cnt = m_cnt + int'(acc) - int'(pop);
        if (setirq) m_irq = 1;
        else if (c) m_irq = 0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drain_all();
        while (m_cnt != 0) step(0, '0, 0);
        step(0, '0, 0);
    endtask

    initial begin
        for (int i = 0; i < D; i++) begin m_q[i] = 0; m_k[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset level", int'(level), 0);
        chk("R1 reset enq_ready", int'(enq_ready), 1);
        chk("R1 reset irq_status", int'(irq_status), 0);

        for (int p = 0; p < 5; p++) begin
            int eff;
            int base;
            period = 8'(p);
            eff = (p == 0) ? 1 : p;

            // slow producer: the drain keeps pace, the ring never fills
            base = marks_seen;
            for (int n = 0; n < 20; n++) begin
                step(1, tag, 0); tag++;
                for (int w = 0; w < eff + 1; w++) step(0, '0, 0);
            end
            drain_all();
            chk("R6 no flag when never full", marks_seen - base, 0);
            chk("R6 no irq when never full", int'(irq_status), 0);

            // burst producer: pushes every cycle, including while stalled
            base = marks_seen;
            for (int n = 0; n < 40; n++) begin step(1, tag, 0); tag++; end
            drain_all();
            if (eff >= 2) begin
                chk("R5 flag retired after fill", int'(marks_seen - base > 0), 1);
                chk("R7 irq held after flag", int'(irq_status), 1);
            end
            step(0, '0, 1);
            step(0, '0, 0);
            chk("R7 irq cleared by write-one", int'(irq_status), 0);

            // pseudo-random pushes and clears
            for (int n = 0; n < 300; n++) begin
                bit v, c;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                v = (lfsr[2:0] != 3'd0);
                c = (lfsr[7:5] == 3'd3);
                step(v, tag, c); tag++;
            end
            drain_all();
            step(0, '0, 1);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got 0 exp 1 (run did not complete)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule